// File: doc/BRIEF.md
# Two-Operand Integer Execution Unit

This block is the combinational execution stage of a small 16-bit processor core whose register operations overwrite their first source. The issue stage supplies a decoded operation code, the value of the register that is both destination and first operand, the value of the second register, an immediate that has already been widened to 16 bits, and the program counter of the instruction. In the same cycle the unit returns the value to be written back, a write enable, and, for the two register-jump operations, a jump target with a valid flag.

Arithmetic, logic, set-if-less-than compares and the barrel shifts all share one adder and one shifter. Each has a register form and an immediate form. Register moves, immediate loads, upper-immediate loads, PC-relative upper-immediate adds and the link values of both jump-and-link forms also come from this unit, so that the pipeline needs only one writeback path. Branch resolution, memory access and the register file live elsewhere. Operations that never write a register are represented by a single "no writeback" code.

Top module: `exu16_alu`

## Requirements
- R1: ADD gives rd + rs2 and SUB gives rd - rs2, both wrapping modulo 2^16 with no flag outputs.
- R2: SLT compares rd and rs2 as signed values and SLTU compares them as unsigned values. The result is 1 when rd is less and 0 otherwise, so bits 15..1 are always zero.
- R3: OR, AND and XOR combine rd and rs2 bit by bit.
- R4: SLL, SRL and SRA shift rd by rs2[3:0], and rs2[15:4] has no effect. SRL fills with zeros and SRA copies bit 15 of rd into the vacated positions.
- R5: SLLI, SRLI and SRAI shift rd by imm[3:0] with the same fill rules, and imm[15:4] has no effect.
- R6: ADDI, SLTI, ORI, ANDI and XORI use the 16-bit immediate input in place of rs2. SLTI compares as signed and ADDI wraps modulo 2^16.
- R7: SLTUI gives 1 when rd is less than the immediate with both read as unsigned, so an immediate of 0xFFFF yields 1 for any rd below 0xFFFF.
- R8: MV gives rs2 and LI gives the immediate unchanged.
- R9: LUI gives the immediate with bits 6..0 forced to zero. AUIPC gives pc plus that masked value, modulo 2^16.
- R10: JAL and JALR give pc + 2 as the written value, modulo 2^16, so a pc of 0xFFFE yields 0x0000.
- R11: The jump-valid output is 1 only for JR and JALR. The target is rd for JR and rs2 for JALR, which is the value read before the link is written. The target is 0 whenever jump-valid is 0.
- R12: Write enable is 0 for JR and for the no-writeback code, and 1 for every other operation. The result output reads 0 whenever write enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Decoded operation, coded as the `op_e` enumeration in `exu16_pkg` |
| rd_val_i | input | 16 | Value of the destination / first source register |
| rs2_val_i | input | 16 | Value of the second source register |
| imm_i | input | 16 | Immediate, already extended to 16 bits |
| pc_i | input | 16 | Program counter of the instruction |
| result_o | output | 16 | Value to write back |
| wb_en_o | output | 1 | Register write enable |
| jmp_tgt_o | output | 16 | Register-jump target address |
| jmp_vld_o | output | 1 | Target is valid (JR or JALR) |

## Verification
Some cases are hard to reach from the ports. One is a signed compare whose subtraction overflows, where the operands differ in sign and lie far apart. Others are shifts by 15 of a value with only bit 15 set, and shift sources whose ignored upper bits are non-zero. Uniform random operands seldom land on these, so the stimulus applies them as directed vectors. It then runs a long random phase in which each operand is drawn, with high probability, from a small set of edge values (0x0000, 0x7FFF, 0x8000, 0xFFFF, 0xFFFE). This covers every operation code, with the program counter near the top of the address space so that the link and AUIPC sums wrap.

// File: rtl/exu16_pkg.sv
package exu16_pkg;

    localparam int unsigned DATA_W = 16;

    typedef enum logic [4:0] {
        OP_ADD, OP_SUB, OP_SLT, OP_SLTU, OP_SLL, OP_SRL, OP_SRA,
        OP_OR, OP_AND, OP_XOR, OP_MV, OP_JR, OP_JALR,
        OP_ADDI, OP_SLTI, OP_SLTUI, OP_SLLI, OP_SRLI, OP_SRAI,
        OP_ORI, OP_ANDI, OP_XORI, OP_LI, OP_LUI, OP_AUIPC,
        OP_JAL, OP_NONE
    } op_e;

    localparam int unsigned OP_COUNT = 27;

    typedef enum logic [1:0] {SH_LEFT, SH_RLOG, SH_RARI} shkind_e;
    typedef enum logic [1:0] {BW_OR, BW_AND, BW_XOR} bwkind_e;

    typedef struct packed {
        logic use_imm;
        logic sub;
        logic wb;
        logic tgt;
    } ctl_t;

    function automatic ctl_t decode_ctl(op_e op);
        ctl_t c;
        c.use_imm = op inside {OP_ADDI, OP_SLTI, OP_SLTUI, OP_SLLI, OP_SRLI,
                               OP_SRAI, OP_ORI, OP_ANDI, OP_XORI, OP_LI};
        c.sub     = op inside {OP_SUB, OP_SLT, OP_SLTU, OP_SLTI, OP_SLTUI};
        c.wb      = !(op inside {OP_JR, OP_NONE});
        c.tgt     = op inside {OP_JR, OP_JALR};
        return c;
    endfunction

    function automatic shkind_e shift_kind(op_e op);
        case (op)
            OP_SRL, OP_SRLI: return SH_RLOG;
            OP_SRA, OP_SRAI: return SH_RARI;
            default:         return SH_LEFT;
        endcase
    endfunction

    function automatic bwkind_e bw_kind(op_e op);
        case (op)
            OP_AND, OP_ANDI: return BW_AND;
            OP_XOR, OP_XORI: return BW_XOR;
            default:         return BW_OR;
        endcase
    endfunction

endpackage

// File: rtl/exu16_addsub.sv
module exu16_addsub #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         lt_s_o,
    output logic         lt_u_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   ext;

    assign b_eff  = sub_i ? ~b_i : b_i;
    assign ext    = {1'b0, a_i} + {1'b0, b_eff} + (W+1)'(sub_i);
    assign sum_o  = ext[W-1:0];
    // Borrow out of the subtraction means a < b unsigned.
    assign lt_u_o = sub_i & ~ext[W];
    // Differing signs decide directly; otherwise the difference sign does.
    assign lt_s_o = (a_i[W-1] ^ b_i[W-1]) ? a_i[W-1] : ext[W-1];
endmodule

// File: rtl/exu16_shift.sv
module exu16_shift
    import exu16_pkg::*;
#(
    parameter int unsigned W  = 16,
    localparam int unsigned SW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    input  shkind_e       kind_i,
    output logic [W-1:0]  res_o
);
    logic         left;
    logic         fill;
    logic [W-1:0] src;
    logic [W-1:0] stage [SW+1];

    assign left = (kind_i == SH_LEFT);
    assign fill = (kind_i == SH_RARI) & data_i[W-1];

    // Left shifts run through the right shifter on a bit-reversed word.
    for (genvar i = 0; i < W; i++) begin : g_rev_in
        assign src[i] = left ? data_i[W-1-i] : data_i[i];
    end

    assign stage[0] = src;
    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int unsigned D = 2 ** s;
        assign stage[s+1] = amt_i[s] ? {{D{fill}}, stage[s][W-1:D]} : stage[s];
    end

    for (genvar i = 0; i < W; i++) begin : g_rev_out
        assign res_o[i] = left ? stage[SW][W-1-i] : stage[SW][i];
    end
endmodule

// File: rtl/exu16_bitwise.sv
module exu16_bitwise
    import exu16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  bwkind_e      kind_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        case (kind_i)
            BW_AND:  res_o = a_i & b_i;
            BW_XOR:  res_o = a_i ^ b_i;
            default: res_o = a_i | b_i;
        endcase
    end
endmodule

// File: rtl/exu16_alu.sv
module exu16_alu
    import exu16_pkg::*;
#(
    parameter int unsigned W        = DATA_W,
    parameter int unsigned ULOW     = 7,
    parameter int unsigned LINK_INC = 2,
    localparam int unsigned SW      = $clog2(W)
) (
    input  logic [4:0]   op_i,
    input  logic [W-1:0] rd_val_i,
    input  logic [W-1:0] rs2_val_i,
    input  logic [W-1:0] imm_i,
    input  logic [W-1:0] pc_i,
    output logic [W-1:0] result_o,
    output logic         wb_en_o,
    output logic [W-1:0] jmp_tgt_o,
    output logic         jmp_vld_o
);
    op_e          op;
    ctl_t         ctl;
    logic [W-1:0] uimm, opa, opb, link;
    logic [W-1:0] sum, sh_res, bw_res, res;
    logic [SW-1:0] shamt;
    logic         lt_s, lt_u;

    assign op   = op_e'(op_i);
    assign ctl  = decode_ctl(op);
    assign uimm = {imm_i[W-1:ULOW], {ULOW{1'b0}}};
    assign link = pc_i + W'(LINK_INC);

    assign opa   = (op == OP_AUIPC) ? pc_i : rd_val_i;
    assign opb   = (op == OP_AUIPC) ? uimm : (ctl.use_imm ? imm_i : rs2_val_i);
    assign shamt = ctl.use_imm ? imm_i[SW-1:0] : rs2_val_i[SW-1:0];

    exu16_addsub #(.W(W)) i_addsub (
        .a_i    (opa),
        .b_i    (opb),
        .sub_i  (ctl.sub),
        .sum_o  (sum),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    exu16_shift #(.W(W)) i_shift (
        .data_i (rd_val_i),
        .amt_i  (shamt),
        .kind_i (shift_kind(op)),
        .res_o  (sh_res)
    );

    exu16_bitwise #(.W(W)) i_bitwise (
        .a_i    (rd_val_i),
        .b_i    (opb),
        .kind_i (bw_kind(op)),
        .res_o  (bw_res)
    );

    always_comb begin
        case (op)
            OP_ADD, OP_SUB, OP_ADDI, OP_AUIPC: res = sum;
            OP_SLT, OP_SLTI:                   res = W'(lt_s);
            OP_SLTU, OP_SLTUI:                 res = W'(lt_u);
            OP_SLL, OP_SRL, OP_SRA,
            OP_SLLI, OP_SRLI, OP_SRAI:         res = sh_res;
            OP_OR, OP_AND, OP_XOR,
            OP_ORI, OP_ANDI, OP_XORI:          res = bw_res;
            OP_MV:                             res = rs2_val_i;
            OP_LI:                             res = imm_i;
            OP_LUI:                            res = uimm;
            OP_JAL, OP_JALR:                   res = link;
            default:                           res = '0;
        endcase
    end

    assign wb_en_o   = ctl.wb;
    assign result_o  = ctl.wb ? res : '0;
    assign jmp_vld_o = ctl.tgt;
    assign jmp_tgt_o = (op == OP_JR)   ? rd_val_i  :
                       (op == OP_JALR) ? rs2_val_i : '0;
endmodule

// File: rtl/exu16_alu_chk.sv
module exu16_alu_chk
    import exu16_pkg::*;
(
    input logic [4:0]  op_i,
    input logic [15:0] rd_val_i,
    input logic [15:0] rs2_val_i,
    input logic [15:0] pc_i,
    input logic [15:0] result_o,
    input logic        wb_en_o,
    input logic [15:0] jmp_tgt_o,
    input logic        jmp_vld_o
);
    op_e op;
    assign op = op_e'(op_i);

    always_comb begin
        if (op inside {OP_SLT, OP_SLTU, OP_SLTI, OP_SLTUI})
            assert_cmp_single_bit_R2: assert (result_o[15:1] == 15'd0)
                else $error("compare result wider than one bit");
        if (op == OP_SRL && rs2_val_i[3:0] != 4'd0)
            assert_srl_zero_fill_R4: assert (result_o[15] == 1'b0)
                else $error("logical right shift left bit 15 set");
        if (op == OP_LUI)
            assert_lui_low_clear_R9: assert (result_o[6:0] == 7'd0)
                else $error("upper immediate low bits not cleared");
        if (op inside {OP_JAL, OP_JALR})
            assert_link_value_R10: assert (result_o == pc_i + 16'd2)
                else $error("link value is not pc + 2");
        if (op == OP_JALR)
            assert_jalr_target_R11: assert (jmp_vld_o && jmp_tgt_o == rs2_val_i)
                else $error("JALR target is not rs2");
        if (op == OP_JR)
            assert_jr_target_R11: assert (jmp_vld_o && jmp_tgt_o == rd_val_i)
                else $error("JR target is not rd");
        if (!jmp_vld_o)
            assert_tgt_idle_zero_R11: assert (jmp_tgt_o == 16'd0)
                else $error("target non-zero without jump");
        if (!wb_en_o)
            assert_no_wb_zero_R12: assert (result_o == 16'd0)
                else $error("result non-zero without writeback");
    end
endmodule

bind exu16_alu exu16_alu_chk i_exu16_alu_chk (
    .op_i      (op_i),
    .rd_val_i  (rd_val_i),
    .rs2_val_i (rs2_val_i),
    .pc_i      (pc_i),
    .result_o  (result_o),
    .wb_en_o   (wb_en_o),
    .jmp_tgt_o (jmp_tgt_o),
    .jmp_vld_o (jmp_vld_o)
);

// File: tb/test_exu16_alu.sv
`timescale 1ns/1ps
module test_exu16_alu;
    import exu16_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [4:0]  op;
    logic [15:0] rd, rs2, imm, pc;
    logic [15:0] result, tgt;
    logic        wb_en, tgt_vld;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    exu16_alu i_exu16_alu (
        .op_i      (op),
        .rd_val_i  (rd),
        .rs2_val_i (rs2),
        .imm_i     (imm),
        .pc_i      (pc),
        .result_o  (result),
        .wb_en_o   (wb_en),
        .jmp_tgt_o (tgt),
        .jmp_vld_o (tgt_vld)
    );

    function automatic int sx(int v);
        return (v >= 32768) ? v - 65536 : v;
    endfunction

    // Behavioural reference written from the requirements.
    task automatic model(input op_e o, input int a, input int b, input int i,
                         input int p, output int res, output bit wb,
                         output int t, output bit tv, output string tag);
        res = 0; wb = 1'b1; t = 0; tv = 1'b0; tag = "R12";
        case (o)
            OP_ADD:   begin res = (a + b) & 65535;              tag = "R1"; end
            OP_SUB:   begin res = (a - b) & 65535;              tag = "R1"; end
            OP_SLT:   begin res = (sx(a) < sx(b)) ? 1 : 0;      tag = "R2"; end
            OP_SLTU:  begin res = (a < b) ? 1 : 0;              tag = "R2"; end
            OP_OR:    begin res = a | b;                        tag = "R3"; end
            OP_AND:   begin res = a & b;                        tag = "R3"; end
            OP_XOR:   begin res = a ^ b;                        tag = "R3"; end
            OP_SLL:   begin res = (a << (b % 16)) & 65535;      tag = "R4"; end
            OP_SRL:   begin res = a >> (b % 16);                tag = "R4"; end
            OP_SRA:   begin res = (sx(a) >>> (b % 16)) & 65535; tag = "R4"; end
            OP_SLLI:  begin res = (a << (i % 16)) & 65535;      tag = "R5"; end
            OP_SRLI:  begin res = a >> (i % 16);                tag = "R5"; end
            OP_SRAI:  begin res = (sx(a) >>> (i % 16)) & 65535; tag = "R5"; end
            OP_ADDI:  begin res = (a + i) & 65535;              tag = "R6"; end
            OP_SLTI:  begin res = (sx(a) < sx(i)) ? 1 : 0;      tag = "R6"; end
            OP_ORI:   begin res = a | i;                        tag = "R6"; end
            OP_ANDI:  begin res = a & i;                        tag = "R6"; end
            OP_XORI:  begin res = a ^ i;                        tag = "R6"; end
            OP_SLTUI: begin res = (a < i) ? 1 : 0;              tag = "R7"; end
            OP_MV:    begin res = b;                            tag = "R8"; end
            OP_LI:    begin res = i;                            tag = "R8"; end
            OP_LUI:   begin res = i - (i % 128);                tag = "R9"; end
            OP_AUIPC: begin res = (p + i - (i % 128)) & 65535;  tag = "R9"; end
            OP_JAL:   begin res = (p + 2) & 65535;              tag = "R10"; end
            OP_JALR:  begin res = (p + 2) & 65535; t = b; tv = 1'b1; tag = "R10"; end
            OP_JR:    begin wb = 1'b0; t = a; tv = 1'b1;        tag = "R11"; end
            default:  begin wb = 1'b0;                          tag = "R12"; end
        endcase
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input op_e o, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] i, input logic [15:0] p);
        int    res, t;
        bit    wb, tv;
        string tag;
        @(posedge clk);
        #1;
        op = o; rd = a; rs2 = b; imm = i; pc = p;
        @(negedge clk);
        model(o, int'(a), int'(b), int'(i), int'(p), res, wb, t, tv, tag);
        check(tag,   $sformatf("%s result", o.name()), int'(result), res);
        check("R12", $sformatf("%s wb_en", o.name()), int'(wb_en), int'(wb));
        check("R11", $sformatf("%s jmp_vld", o.name()), int'(tgt_vld), int'(tv));
        check("R11", $sformatf("%s jmp_tgt", o.name()), int'(tgt), t);
    endtask

    function automatic logic [15:0] pick();
        case ($urandom_range(0, 7))
            0: return 16'h0000;
            1: return 16'h7FFF;
            2: return 16'h8000;
            3: return 16'hFFFF;
            4: return 16'hFFFE;
            default: return 16'($urandom());
        endcase
    endfunction

    initial begin
        op = OP_NONE; rd = '0; rs2 = '0; imm = '0; pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Idle state: no-writeback code drives zero outputs (R12, R11).
        check("R12", "idle result", int'(result), 0);
        check("R12", "idle wb_en", int'(wb_en), 0);
        check("R11", "idle jmp_vld", int'(tgt_vld), 0);
        rst = 1'b0;

        // R1 wrap-around
        apply(OP_ADD,  16'hFFFF, 16'h0001, 16'h1234, 16'h0100);
        apply(OP_SUB,  16'h0000, 16'h0001, 16'h0000, 16'h0100);
        // R2 signed vs unsigned with overflowing difference
        apply(OP_SLT,  16'h8000, 16'h7FFF, 16'h0000, 16'h0000);
        apply(OP_SLTU, 16'h8000, 16'h7FFF, 16'h0000, 16'h0000);
        apply(OP_SLT,  16'h7FFF, 16'h8000, 16'h0000, 16'h0000);
        // R3
        apply(OP_XOR,  16'hA5A5, 16'h0FF0, 16'h0000, 16'h0000);
        // R4 amount from rs2[3:0], upper bits ignored
        apply(OP_SRA,  16'h8000, 16'hFFFF, 16'h0000, 16'h0000);
        apply(OP_SRL,  16'h8000, 16'h00FF, 16'h0000, 16'h0000);
        apply(OP_SLL,  16'h0001, 16'h0013, 16'h0000, 16'h0000);
        // R5 amount from imm[3:0], upper bits ignored
        apply(OP_SRAI, 16'h8001, 16'h0000, 16'hFFF4, 16'h0000);
        apply(OP_SLLI, 16'h00FF, 16'h0000, 16'h0038, 16'h0000);
        // R6, R7
        apply(OP_ADDI, 16'h0005, 16'h0000, 16'hFFC0, 16'h0000);
        apply(OP_SLTI, 16'h0005, 16'h0000, 16'hFFFF, 16'h0000);
        apply(OP_SLTUI,16'h0005, 16'h0000, 16'hFFFF, 16'h0000);
        apply(OP_SLTUI,16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000);
        // R8
        apply(OP_MV,   16'h1111, 16'h2222, 16'h3333, 16'h0000);
        apply(OP_LI,   16'h1111, 16'h2222, 16'hFFC1, 16'h0000);
        // R9 low bits of imm ignored, AUIPC wraps
        apply(OP_LUI,  16'h0000, 16'h0000, 16'hFFFF, 16'h0000);
        apply(OP_AUIPC,16'h0000, 16'h0000, 16'h00FF, 16'hFFF0);
        // R10 link wrap
        apply(OP_JAL,  16'h0000, 16'h0000, 16'h0000, 16'hFFFE);
        apply(OP_JALR, 16'h4444, 16'h5678, 16'h0000, 16'h0100);
        // R11, R12
        apply(OP_JR,   16'hBEEF, 16'h1234, 16'h0000, 16'h0200);
        apply(OP_NONE, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);

        for (int k = 0; k < 4000; k++) begin
            apply(op_e'($urandom_range(0, OP_COUNT - 1)), pick(), pick(), pick(), pick());
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule